// File: doc/BRIEF.md
# Double-Buffered Sample Capture and Drain Controller

This block sits between a sampling converter and a byte-serial storage link. A tick divider produces the conversion strobe. The divider counts either every system clock or only the cycles on which a slow-source enable is high. Each finished sample word that the converter returns is written at once into whichever of two equal buffer halves is currently filling. The converter is never stalled.

Once the filling half holds one storage block, which by default is 256 sixteen-bit words or 512 bytes, the controller redirects writes to the other half. It then streams the full half out one byte at a time over a valid/ready transmit handshake. Filling and draining run side by side, so capture continues without gaps. A new frame is only opened when the previous drain has finished. If a half fills while a drain is still busy, a sticky overrun flag is raised and the filling half is reused instead of touching the half being drained.

Top module: `pp_acq_top`

## Requirements
- R1: With the fast source selected (`srcSel`=0), `convStart` pulses for one cycle every 2^`rateExp` clock cycles, for `rateExp` from 1 to 15. A `rateExp` of 0 behaves as 1.
- R2: With `srcSel`=1, the divider advances only on cycles where `slowEn` is high, so the pulse spacing is 2^`rateExp` enabled cycles.
- R3: Every cycle with `sampleValid` high stores `sampleData` at the next position of the filling half. The bytes drained from a frame are exactly that frame's samples, in capture order.
- R4: `fillHalf` (0 or 1) names the half being written. It is 0 after reset and keeps its value until that half has received `HALF_WORDS` samples.
- R5: When the filling half receives its last sample and no drain is running, the following happens on the clock edge that writes that sample. `fillHalf` toggles, `frameCount` increments by one and `spiValid` rises, so the very next sample lands in the other half.
- R6: A drain presents each word as two bytes, bits [7:0] first and then bits [15:8]. A byte moves on only on a cycle with `spiValid` and `spiReady` both high. While `spiReady` is low, `spiValid` and `spiByte` hold.
- R7: After the last byte of a half is accepted, `spiValid` drops and `frameDone` is high for exactly one cycle, in the cycle that follows the accepting edge.
- R8: If the filling half receives its last sample while a drain is running, `overrun` is set and stays set until reset. `fillHalf` and `frameCount` do not change, and writing restarts at the first entry of the same half. The half being drained is not modified.
- R9: Synchronous reset clears `frameCount`, `overrun`, `frameDone` and `spiValid`, and selects half 0 as the fill target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| srcSel | input | 1 | 0: divider counts every clock; 1: counts only `slowEn` cycles |
| slowEn | input | 1 | One-cycle enable from the slow reference source |
| rateExp | input | 4 | Divider exponent, spacing 2^rateExp |
| convStart | output | 1 | One-cycle conversion start strobe |
| sampleValid | input | 1 | Converter result available this cycle |
| sampleData | input | 16 | Converter result word |
| spiReady | input | 1 | Serial side accepts the presented byte |
| spiValid | output | 1 | A drain byte is presented |
| spiByte | output | 8 | Byte being presented |
| fillHalf | output | 1 | Buffer half currently receiving samples |
| frameCount | output | 16 | Number of frames opened since reset |
| frameDone | output | 1 | One-cycle pulse when a drain completes |
| overrun | output | 1 | Sticky: a half filled while a drain was busy |

## Verification
The embedded properties assume `sampleData` and `sampleValid` come from an external converter that never needs back-pressure. They also assume the serial side may hold `spiReady` low for any length of time. The bench spaces samples four cycles apart, so a drain with a mostly-high ready pattern always finishes before the next half fills. It then provokes the overrun path on purpose by holding ready low through a full half. Reset is held from time zero, so every history-based property starts from a defined state.

// File: rtl/pp_acq_pkg.sv
package pp_acq_pkg;
  // Strobes from the control FSM to the buffer datapath
  typedef struct packed {
    logic wrEn;     // store sampleData at the write pointer
    logic wrHalf;   // half receiving writes
    logic rdStart;  // rewind read pointer for a new drain
    logic rdStep;   // current byte accepted, advance
    logic rdHalf;   // half being drained
  } ppStrobe_t;
endpackage

// File: rtl/pp_tick.sv
module pp_tick #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srcSel,
  input  logic             slowEn,
  input  logic [EXP_W-1:0] rateExp,
  output logic             tick
);
  localparam int CNT_W = (2 ** EXP_W) - 1;
  localparam int LW    = CNT_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic [EXP_W-1:0] expEff;
  logic             stepEn;

  always_comb begin
    expEff = (rateExp == '0) ? EXP_W'(1) : rateExp;
    limit  = CNT_W'((LW'(1) << expEff) - LW'(1));
    stepEn = srcSel ? slowEn : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (stepEn) begin
        if (cnt >= limit) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  // Spacing is at least two enabled cycles, so pulses never touch
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pp_datapath.sv
module pp_datapath
  import pp_acq_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int HALF_WORDS = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  ppStrobe_t           strb,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                wrLast,
  output logic                rdLastByte,
  output logic [7:0]          spiByte
);
  localparam int PTR_W  = $clog2(HALF_WORDS);
  localparam int DEPTH  = 2 * HALF_WORDS;
  localparam int BYTES  = SAMPLE_W / 8;
  localparam int BIDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic [BIDX_W-1:0]   byteIdx;
  logic [SAMPLE_W-1:0] rdWord;

  // Sample storage: one write port, one combinational read port
  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[{strb.wrHalf, wrPtr}] <= sampleData;
  end

  assign wrLast     = (wrPtr == PTR_W'(HALF_WORDS - 1));
  assign rdLastByte = (rdPtr == PTR_W'(HALF_WORDS - 1)) &&
                      (byteIdx == BIDX_W'(BYTES - 1));

  // Write pointer wraps after the last entry whether or not halves swap
  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
    end else if (strb.wrEn) begin
      wrPtr <= wrLast ? '0 : wrPtr + PTR_W'(1);
    end
  end

  // Read side: byte index within the word, then word pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr   <= '0;
      byteIdx <= '0;
    end else if (strb.rdStart) begin
      rdPtr   <= '0;
      byteIdx <= '0;
    end else if (strb.rdStep) begin
      if (byteIdx == BIDX_W'(BYTES - 1)) begin
        byteIdx <= '0;
        rdPtr   <= (rdPtr == PTR_W'(HALF_WORDS - 1)) ? '0 : rdPtr + PTR_W'(1);
      end else begin
        byteIdx <= byteIdx + BIDX_W'(1);
      end
    end
  end

  always_comb begin
    rdWord  = mem[{strb.rdHalf, rdPtr}];
    spiByte = rdWord[8*int'(byteIdx) +: 8];
  end

  // Writes and drain reads must never target the same half together
  assert_split_halves_R8: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && strb.rdStep) |-> (strb.wrHalf != strb.rdHalf));
endmodule

// File: rtl/pp_ctrl.sv
module pp_ctrl
  import pp_acq_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sampleValid,
  input  logic               spiReady,
  input  logic               wrLast,
  input  logic               rdLastByte,
  output ppStrobe_t          strb,
  output logic               fillHalf,
  output logic               draining,
  output logic [FRAME_W-1:0] frameCount,
  output logic               frameDone,
  output logic               overrun
);
  logic drainHalf;
  logic swapReq;
  logic xfer;

  always_comb begin
    swapReq      = sampleValid && wrLast;
    xfer         = draining && spiReady;
    strb.wrEn    = sampleValid;
    strb.wrHalf  = fillHalf;
    strb.rdStart = swapReq && !draining;
    strb.rdStep  = xfer;
    strb.rdHalf  = drainHalf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillHalf   <= 1'b0;
      drainHalf  <= 1'b1;
      draining   <= 1'b0;
      frameCount <= '0;
      frameDone  <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (swapReq && !draining) begin
        fillHalf   <= ~fillHalf;
        drainHalf  <= fillHalf;
        draining   <= 1'b1;
        frameCount <= frameCount + FRAME_W'(1);
      end else if (swapReq) begin
        overrun <= 1'b1;
      end
      if (xfer && rdLastByte) begin
        draining  <= 1'b0;
        frameDone <= 1'b1;
      end
    end
  end

  assert_swap_opens_frame_R5: assert property (@(posedge clk) disable iff (rst)
    (swapReq && !draining) |=> (draining && (fillHalf != $past(fillHalf))));

  assert_frame_step_R5: assert property (@(posedge clk) disable iff (rst)
    (frameCount != $past(frameCount)) |-> (frameCount == $past(frameCount) + FRAME_W'(1)));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_busy_half_kept_R8: assert property (@(posedge clk) disable iff (rst)
    (swapReq && draining) |=> $stable(fillHalf) && $stable(frameCount));
endmodule

// File: rtl/pp_acq_top.sv
module pp_acq_top
  import pp_acq_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int HALF_WORDS = 256,
  parameter int FRAME_W    = 16,
  parameter int EXP_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                srcSel,
  input  logic                slowEn,
  input  logic [EXP_W-1:0]    rateExp,
  output logic                convStart,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                spiReady,
  output logic                spiValid,
  output logic [7:0]          spiByte,
  output logic                fillHalf,
  output logic [FRAME_W-1:0]  frameCount,
  output logic                frameDone,
  output logic                overrun
);
  ppStrobe_t strb;
  logic      wrLast;
  logic      rdLastByte;

  pp_tick #(.EXP_W(EXP_W)) uTick (
    .clk(clk), .rst(rst), .srcSel(srcSel), .slowEn(slowEn),
    .rateExp(rateExp), .tick(convStart)
  );

  pp_ctrl #(.FRAME_W(FRAME_W)) uCtrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .spiReady(spiReady),
    .wrLast(wrLast), .rdLastByte(rdLastByte), .strb(strb),
    .fillHalf(fillHalf), .draining(spiValid), .frameCount(frameCount),
    .frameDone(frameDone), .overrun(overrun)
  );

  pp_datapath #(.SAMPLE_W(SAMPLE_W), .HALF_WORDS(HALF_WORDS)) uData (
    .clk(clk), .rst(rst), .strb(strb), .sampleData(sampleData),
    .wrLast(wrLast), .rdLastByte(rdLastByte), .spiByte(spiByte)
  );

  // A presented byte stays put until the serial side takes it
  assert_spi_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (spiValid && !spiReady) |=> (spiValid && $stable(spiByte)));
endmodule

// File: tb/sim_pp_acq_top.sv
`timescale 1ns/1ps
module sim_pp_acq_top;
  localparam int HW = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        srcSel = 1'b0;
  logic        slowEn = 1'b0;
  logic [3:0]  rateExp = 4'd1;
  logic        convStart;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleData = '0;
  logic        spiReady = 1'b0;
  logic        spiValid;
  logic [7:0]  spiByte;
  logic        fillHalf;
  logic [15:0] frameCount;
  logic        frameDone;
  logic        overrun;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  int readyMode = 0;
  bit slowMode = 1'b0;
  int cyc = 0;
  int doneCount = 0;
  int popCount = 0;
  logic [7:0] expQ[$];

  always #10 clk = ~clk;

  pp_acq_top u0 (
    .clk(clk), .rst(rst), .srcSel(srcSel), .slowEn(slowEn), .rateExp(rateExp),
    .convStart(convStart), .sampleValid(sampleValid), .sampleData(sampleData),
    .spiReady(spiReady), .spiValid(spiValid), .spiByte(spiByte),
    .fillHalf(fillHalf), .frameCount(frameCount), .frameDone(frameDone),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Ready and slow-enable drivers, changed just after each rising edge
  initial begin
    forever begin
      @(posedge clk); #2;
      cyc++;
      case (readyMode)
        0: spiReady = 1'b0;
        1: spiReady = 1'b1;
        default: spiReady = (cyc % 4) != 0;
      endcase
      slowEn = slowMode && ((cyc % 3) == 0);
    end
  end

  // Monitor: scoreboard pops, hold and done-pulse checks at falling edges
  initial begin
    bit prevStall = 1'b0;
    bit expectDone = 1'b0;
    logic [7:0] prevByte = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (frameDone) doneCount++;
        if (expectDone) begin
          chk(frameDone && !spiValid, "R7 done pulse / valid drop", int'(frameDone), 1);
          expectDone = 1'b0;
        end
        if (prevStall)
          chk(spiValid && (spiByte == prevByte), "R6 byte held while not ready",
              int'(spiByte), int'(prevByte));
        if (spiValid && spiReady) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R3 unexpected drained byte", int'(spiByte), -1);
          end else begin
            logic [7:0] e;
            e = expQ.pop_front();
            chk(spiByte == e, "R3 R6 drained byte order", int'(spiByte), int'(e));
          end
          popCount++;
          if ((popCount % (2 * HW)) == 0) expectDone = 1'b1;
        end
        prevStall = spiValid && !spiReady;
        prevByte  = spiByte;
      end
    end
  end

  function automatic logic [15:0] mkData(input int frame, input int k);
    return 16'((frame * 4099) + (k * 131) + 16'h5a3c);
  endfunction

  // Driver: one sample every four cycles; called and returns at posedge+2
  task automatic putSample(input logic [15:0] d, input bit keep);
    sampleValid = 1'b1;
    sampleData  = d;
    if (keep) begin
      expQ.push_back(d[7:0]);
      expQ.push_back(d[15:8]);
    end
    @(posedge clk); #2;
    sampleValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
  endtask

  // Writes a full half; returns at the falling edge after the last write
  task automatic fillBlock(input int frame, input bit keep, input logic halfNow);
    for (int k = 0; k < HW - 1; k++) putSample(mkData(frame, k), keep);
    chk(fillHalf == halfNow, "R4 half held until full", int'(fillHalf), int'(halfNow));
    sampleValid = 1'b1;
    sampleData  = mkData(frame, HW - 1);
    if (keep) begin
      expQ.push_back(sampleData[7:0]);
      expQ.push_back(sampleData[15:8]);
    end
    @(posedge clk); #2;
    sampleValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic measureTick(input logic [3:0] e, input bit slow, input int expCycles,
                             input string tag);
    int c;
    @(posedge clk); #2;
    rateExp  = e;
    srcSel   = slow;
    slowMode = slow;
    do @(negedge clk); while (!convStart);
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (!convStart);
    chk(c == expCycles, tag, c, expCycles);
  endtask

  task automatic waitDrainIdle();
    for (int i = 0; i < 4000 && spiValid; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(frameCount == 0, "R9 frameCount after reset", int'(frameCount), 0);
    chk(fillHalf == 1'b0, "R9 fillHalf after reset", int'(fillHalf), 0);
    chk(!spiValid, "R9 drain idle after reset", int'(spiValid), 0);
    chk(!overrun && !frameDone, "R9 flags clear after reset", int'(overrun), 0);

    // R1 / R2 tick divider
    measureTick(4'd1, 1'b0, 2, "R1 spacing exp=1");
    measureTick(4'd4, 1'b0, 16, "R1 spacing exp=4");
    measureTick(4'd0, 1'b0, 2, "R1 exp=0 acts as 1");
    measureTick(4'd2, 1'b1, 12, "R2 slow source exp=2");
    measureTick(4'd3, 1'b1, 24, "R2 slow source exp=3");
    measureTick(4'd15, 1'b0, 32768, "R1 spacing exp=15");
    slowMode = 1'b0;

    // Continuous capture with an intermittent ready
    @(posedge clk); #2;
    readyMode = 2;
    fillBlock(1, 1'b1, 1'b0);
    chk(frameCount == 1, "R5 frame count after first swap", int'(frameCount), 1);
    chk(fillHalf == 1'b1, "R4 swapped to half 1", int'(fillHalf), 1);
    chk(spiValid, "R5 drain starts on swap", int'(spiValid), 1);
    @(posedge clk); #2;
    fillBlock(2, 1'b1, 1'b1);
    chk(frameCount == 2, "R5 frame count after second swap", int'(frameCount), 2);
    chk(fillHalf == 1'b0, "R4 swapped back to half 0", int'(fillHalf), 0);
    chk(spiValid, "R5 second drain started", int'(spiValid), 1);
    chk(!overrun, "R8 no overrun when drain keeps up", int'(overrun), 0);
    chk(doneCount == 1, "R7 one drain completed", doneCount, 1);

    // Overrun: stall the serial side through a whole half
    @(posedge clk); #2;
    readyMode = 0;
    fillBlock(3, 1'b0, 1'b0);
    chk(overrun, "R8 overrun raised", int'(overrun), 1);
    chk(frameCount == 2, "R8 frame count frozen", int'(frameCount), 2);
    chk(fillHalf == 1'b0, "R8 fill half unchanged", int'(fillHalf), 0);
    chk(spiValid, "R8 stalled drain still active", int'(spiValid), 1);
    @(posedge clk); #2;
    readyMode = 1;
    waitDrainIdle();
    repeat (2) @(negedge clk);
    chk(doneCount == 2, "R7 stalled drain completed", doneCount, 2);
    chk(overrun, "R8 overrun sticky", int'(overrun), 1);

    // Recovery: the reused half fills again and drains
    @(posedge clk); #2;
    fillBlock(4, 1'b1, 1'b0);
    chk(frameCount == 3, "R5 frame count after recovery", int'(frameCount), 3);
    chk(fillHalf == 1'b1, "R4 swap after recovery", int'(fillHalf), 1);
    waitDrainIdle();
    repeat (2) @(negedge clk);
    chk(doneCount == 3, "R7 total drains", doneCount, 3);
    chk(expQ.size() == 0, "R3 all kept samples drained", expQ.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule